// File: doc/BRIEF.md
# Memory barrier stall controller

This block owns the memory-stage slot of an in-order pipeline and decides how long an ordering barrier stays there. An instruction leaving execute carries a 3-bit class code. Four of the codes are barrier kinds: full, write, exception and trap. Each barrier kind turns into one of two stall requests. The first is a general "needs barrier" request, used by the full, exception and trap kinds. The second is a "needs write-buffer drain" request, used by the write kind. While the request in the slot has no completion, the block holds the slot and asserts a stall back to execute.

A per-slot completion flag is the only thing that can release a barrier. A completion unit sets this flag, and it evaluates the kind-specific condition every cycle. The condition inputs come from the memory side:

- a local write-buffer empty signal
- per-CPU acknowledgments of a broadcast barrier request
- a count of unfinished older instructions
- a pending-exception indicator
- a count of unfinished floating-point-trapping instructions

The pipeline itself never drops a request. The only exception is a flush, which discards the slot entirely.

Once the flag is set, the slot commits on the following edge and presents its tag and class on the writeback outputs. An ordinary instruction passes through the slot in a single cycle, with no stall.

Top module: `barrier_stall_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `mem_stall`, `wb_valid`, `bar_req_out`, `need_bar` and `need_drain` are all 0.
- R2: An instruction whose class code is not a barrier is accepted at an edge and appears on `wb_valid`/`wb_tag`/`wb_kind` after the next edge, with `mem_stall` low throughout. The non-barrier codes are 0 and 5 to 7, and all of them are reported as `wb_kind` 0.
- R3: The barrier codes are 1 (full), 2 (write), 3 (exception) and 4 (trap). After the edge that accepts a barrier, `mem_stall` is high. Codes 1, 3 and 4 raise `need_bar` only. Code 2 raises `need_drain` only.
- R4: A write barrier is released by `wbuf_empty` alone. Suppose `wbuf_empty` is high at edge e while the barrier is stalled. Then `mem_stall` falls after e, and the barrier reaches writeback after e+1.
- R5: Accepting a full barrier produces a single-cycle `bar_req_out` pulse after the accepting edge. The barrier completes only when every CPU set in `cpu_present` has acknowledged it and `wbuf_empty` is high.
- R6: An exception barrier stays stalled while `older_cnt` is nonzero or `exc_pending` is high. It is released when both are clear.
- R7: A trap barrier stays stalled while `fp_trap_cnt` is nonzero, and is released when it reaches zero. `exc_pending` and `older_cnt` have no effect on it.
- R8: A stalled barrier whose condition stays false keeps `mem_stall` high for any number of cycles.
- R9: `flush` empties the slot without a writeback and drops any request. It also clears the recorded acknowledgments, so a later full barrier needs fresh acknowledgments from every CPU.
- R10: Non-barrier instructions offered on consecutive cycles are each accepted and retire on consecutive cycles, in order.
- R11: Acknowledgments from CPUs absent in `cpu_present` are ignored. Acknowledgments arriving while no full barrier is waiting are also ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard memory-stage slot and any pending barrier |
| ex_valid | input | 1 | Execute stage offers an instruction |
| ex_kind | input | 3 | Instruction class code (see R2, R3) |
| ex_tag | input | TAG_W | Identifier carried to writeback |
| mem_stall | output | 1 | Slot held on an uncompleted barrier; execute must hold |
| need_bar | output | 1 | Slot carries a general barrier request |
| need_drain | output | 1 | Slot carries a write-buffer drain request |
| bar_req_out | output | 1 | One-cycle barrier request broadcast to all CPUs |
| cpu_ack | input | NCPU | Per-CPU barrier acknowledgments |
| cpu_present | input | NCPU | Mask of CPUs taking part |
| wbuf_empty | input | 1 | Local write buffer empty |
| older_cnt | input | CNT_W | Unfinished older instructions |
| exc_pending | input | 1 | An exception is unresolved |
| fp_trap_cnt | input | CNT_W | Unfinished instructions that may raise arithmetic traps |
| wb_valid | output | 1 | Slot retired to writeback this cycle |
| wb_kind | output | 3 | Class code of retiring instruction |
| wb_tag | output | TAG_W | Tag of retiring instruction |

## Verification
A non-barrier instruction accepted at edge t is due at writeback after edge t+1. A barrier whose condition holds at edge e has `mem_stall` low after e and retires after e+1. For a full barrier, an acknowledgment sampled at edge a only counts at edge a+1, so the earliest release comes one edge later. The bench drives on falling edges and samples at the falling edge that follows each counted rising edge. It uses exactly these offsets for its timing checks. A scoreboard queue confirms the order and content of every retirement.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    BK_PLAIN  = 3'd0,
    BK_FULL   = 3'd1,
    BK_WRITE  = 3'd2,
    BK_EXCEPT = 3'd3,
    BK_TRAP   = 3'd4
  } bar_kind_e;

  typedef struct packed {
    logic need_bar;
    logic need_drain;
    logic is_full;
  } bar_req_t;
endpackage

// File: rtl/barrier_decode.sv
module barrier_decode
  import barrier_pkg::*;
(
  input  logic [KIND_W-1:0] kind_raw,
  output bar_kind_e         kind,
  output bar_req_t          req
);
  always_comb begin
    case (kind_raw)
      3'd1:    kind = BK_FULL;
      3'd2:    kind = BK_WRITE;
      3'd3:    kind = BK_EXCEPT;
      3'd4:    kind = BK_TRAP;
      default: kind = BK_PLAIN;
    endcase
  end

  always_comb begin
    req            = '0;
    req.need_bar   = (kind == BK_FULL) || (kind == BK_EXCEPT) || (kind == BK_TRAP);
    req.need_drain = (kind == BK_WRITE);
    req.is_full    = (kind == BK_FULL);
  end
endmodule

// File: rtl/barrier_ack_track.sv
module barrier_ack_track #(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            clear,
  input  logic            launch,
  input  logic            armed,
  input  logic [NCPU-1:0] cpu_ack,
  input  logic [NCPU-1:0] cpu_present,
  output logic            bcast,
  output logic            all_acked
);
  logic [NCPU-1:0] seen;

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    logic seen_q;
    always_ff @(posedge clk) begin
      if (rst || flush || clear)
        seen_q <= 1'b0;
      else if (armed && cpu_present[i] && cpu_ack[i])
        seen_q <= 1'b1;
    end
    assign seen[i] = seen_q;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) bcast <= 1'b0;
    else              bcast <= launch;
  end

  assign all_acked = &(seen | ~cpu_present);
endmodule

// File: rtl/barrier_complete.sv
module barrier_complete
  import barrier_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             commit,
  input  logic             pending,
  input  bar_kind_e        slot_kind,
  input  logic             all_acked,
  input  logic             wbuf_empty,
  input  logic [CNT_W-1:0] older_cnt,
  input  logic             exc_pending,
  input  logic [CNT_W-1:0] fp_trap_cnt,
  output logic             done_q
);
  logic cond;

  always_comb begin
    case (slot_kind)
      BK_FULL:   cond = all_acked && wbuf_empty;
      BK_WRITE:  cond = wbuf_empty;
      BK_EXCEPT: cond = (older_cnt == '0) && !exc_pending;
      BK_TRAP:   cond = (fp_trap_cnt == '0);
      default:   cond = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || flush || commit)
      done_q <= 1'b0;
    else if (pending && cond)
      done_q <= 1'b1;
  end
endmodule

// File: rtl/barrier_stall_ctrl.sv
module barrier_stall_ctrl
  import barrier_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CNT_W = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             ex_valid,
  input  logic [2:0]       ex_kind,
  input  logic [TAG_W-1:0] ex_tag,
  output logic             mem_stall,
  output logic             need_bar,
  output logic             need_drain,
  output logic             bar_req_out,
  input  logic [NCPU-1:0]  cpu_ack,
  input  logic [NCPU-1:0]  cpu_present,
  input  logic             wbuf_empty,
  input  logic [CNT_W-1:0] older_cnt,
  input  logic             exc_pending,
  input  logic [CNT_W-1:0] fp_trap_cnt,
  output logic             wb_valid,
  output logic [2:0]       wb_kind,
  output logic [TAG_W-1:0] wb_tag
);
  bar_kind_e        ex_kind_d;
  bar_req_t         ex_req_d;
  logic             slot_valid;
  bar_kind_e        slot_kind;
  bar_req_t         slot_req;
  logic [TAG_W-1:0] slot_tag;
  logic             done_q;
  logic             all_acked;
  logic             stall_w;
  logic             commit;
  logic             load;
  logic             launch;
  logic             armed;

  barrier_decode u_dec (
    .kind_raw (ex_kind),
    .kind     (ex_kind_d),
    .req      (ex_req_d)
  );

  assign stall_w = slot_valid && (slot_req.need_bar || slot_req.need_drain) && !done_q;
  assign commit  = slot_valid && !stall_w;
  assign load    = ex_valid && !stall_w && !flush;
  assign launch  = load && ex_req_d.is_full;
  assign armed   = slot_valid && slot_req.is_full && !done_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      slot_valid <= 1'b0;
      slot_kind  <= BK_PLAIN;
      slot_req   <= '0;
      slot_tag   <= '0;
    end else if (load) begin
      slot_valid <= 1'b1;
      slot_kind  <= ex_kind_d;
      slot_req   <= ex_req_d;
      slot_tag   <= ex_tag;
    end else if (commit) begin
      slot_valid <= 1'b0;
      slot_req   <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wb_valid <= 1'b0;
      wb_kind  <= '0;
      wb_tag   <= '0;
    end else begin
      wb_valid <= commit;
      wb_kind  <= slot_kind;
      wb_tag   <= slot_tag;
    end
  end

  barrier_ack_track #(.NCPU(NCPU)) u_ack (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .clear       (commit),
    .launch      (launch),
    .armed       (armed),
    .cpu_ack     (cpu_ack),
    .cpu_present (cpu_present),
    .bcast       (bar_req_out),
    .all_acked   (all_acked)
  );

  barrier_complete #(.CNT_W(CNT_W)) u_cmp (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .commit      (commit),
    .pending     (stall_w),
    .slot_kind   (slot_kind),
    .all_acked   (all_acked),
    .wbuf_empty  (wbuf_empty),
    .older_cnt   (older_cnt),
    .exc_pending (exc_pending),
    .fp_trap_cnt (fp_trap_cnt),
    .done_q      (done_q)
  );

  assign mem_stall  = stall_w;
  assign need_bar   = slot_valid && slot_req.need_bar;
  assign need_drain = slot_valid && slot_req.need_drain;
endmodule

// File: rtl/barrier_stall_ctrl_chk.sv
module barrier_stall_ctrl_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             mem_stall,
  input logic             need_bar,
  input logic             need_drain,
  input logic             bar_req_out,
  input logic             wb_valid,
  input logic [2:0]       wb_kind,
  input logic             wbuf_empty,
  input logic [CNT_W-1:0] older_cnt,
  input logic             exc_pending,
  input logic [CNT_W-1:0] fp_trap_cnt,
  input logic [2:0]       slot_kind,
  input logic             all_acked
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(need_bar && need_drain)); // R3

  AST_BCAST_PULSE: assert property (@(posedge clk) disable iff (rst)
    bar_req_out |=> !bar_req_out); // R5

  AST_FULL_WAITS_ACKS: assert property (@(posedge clk) disable iff (rst)
    (mem_stall && slot_kind == 3'd1 && !all_acked && !flush) |=> mem_stall); // R5

  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_stall && need_drain && !wbuf_empty && !flush) |=> mem_stall); // R8

  AST_EXCEPT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_stall && slot_kind == 3'd3 && (exc_pending || older_cnt != '0) && !flush)
      |=> mem_stall); // R6

  AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_stall && slot_kind == 3'd4 && fp_trap_cnt != '0 && !flush) |=> mem_stall); // R7

  AST_BARRIER_RELEASED_FIRST: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_kind != 3'd0) |-> $past(!mem_stall)); // R4

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!mem_stall && !wb_valid && !need_bar && !need_drain)); // R9
endmodule

bind barrier_stall_ctrl barrier_stall_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .flush       (flush),
  .mem_stall   (mem_stall),
  .need_bar    (need_bar),
  .need_drain  (need_drain),
  .bar_req_out (bar_req_out),
  .wb_valid    (wb_valid),
  .wb_kind     (wb_kind),
  .wbuf_empty  (wbuf_empty),
  .older_cnt   (older_cnt),
  .exc_pending (exc_pending),
  .fp_trap_cnt (fp_trap_cnt),
  .slot_kind   (slot_kind),
  .all_acked   (all_acked)
);

// File: tb/barrier_stall_ctrl_test.sv
`timescale 1ns/1ps
module barrier_stall_ctrl_test;
  localparam int NCPU = 4;
  localparam int CNT_W = 4;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic ex_valid = 1'b0;
  logic [2:0] ex_kind = '0;
  logic [TAG_W-1:0] ex_tag = '0;
  logic mem_stall, need_bar, need_drain, bar_req_out, wb_valid;
  logic [2:0] wb_kind;
  logic [TAG_W-1:0] wb_tag;
  logic [NCPU-1:0] cpu_ack = '0;
  logic [NCPU-1:0] cpu_present = 4'b1011;
  logic wbuf_empty = 1'b1;
  logic [CNT_W-1:0] older_cnt = '0;
  logic exc_pending = 1'b0;
  logic [CNT_W-1:0] fp_trap_cnt = '0;

  always #4 clk = ~clk;

  barrier_stall_ctrl #(.NCPU(NCPU), .CNT_W(CNT_W), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst(rst), .flush(flush), .ex_valid(ex_valid), .ex_kind(ex_kind),
    .ex_tag(ex_tag), .mem_stall(mem_stall), .need_bar(need_bar),
    .need_drain(need_drain), .bar_req_out(bar_req_out), .cpu_ack(cpu_ack),
    .cpu_present(cpu_present), .wbuf_empty(wbuf_empty), .older_cnt(older_cnt),
    .exc_pending(exc_pending), .fp_trap_cnt(fp_trap_cnt), .wb_valid(wb_valid),
    .wb_kind(wb_kind), .wb_tag(wb_tag)
  );

  typedef struct { logic [2:0] k; logic [TAG_W-1:0] t; } exp_t;
  exp_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: offer one instruction, push its expected retirement
  task automatic issue(logic [2:0] k, logic [TAG_W-1:0] t);
    exp_t e;
    @(negedge clk);
    while (mem_stall) @(negedge clk);
    ex_valid = 1'b1; ex_kind = k; ex_tag = t;
    e.k = (k > 3'd4) ? 3'd0 : k;
    e.t = t;
    exp_q.push_back(e);
    @(negedge clk);
    ex_valid = 1'b0;
  endtask

  // monitor: compare every retirement with the queue front
  always @(negedge clk) begin
    if (!rst && wb_valid) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected retirement", {24'd0, wb_tag}, 32'hFFFF);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R2 retire tag", {24'd0, wb_tag}, {24'd0, e.t});
        chk("R2 retire kind", {29'd0, wb_kind}, {29'd0, e.k});
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    tick(3);
    chk("R1 stall in reset", {31'd0, mem_stall}, 0);
    chk("R1 wb in reset", {31'd0, wb_valid}, 0);
    chk("R1 bcast in reset", {31'd0, bar_req_out}, 0);
    chk("R1 requests in reset", {30'd0, need_bar, need_drain}, 0);
    rst = 1'b0;
    tick(1);
    chk("R1 idle after reset", {28'd0, mem_stall, wb_valid, need_bar, need_drain}, 0);

    // plain instruction (R2)
    issue(3'd0, 8'h11);
    chk("R2 no stall", {31'd0, mem_stall}, 0);
    chk("R3 plain no request", {30'd0, need_bar, need_drain}, 0);
    tick(1);
    chk("R2 retire one edge later", {31'd0, wb_valid}, 1);
    // unknown code acts as plain (R2)
    issue(3'd7, 8'h12);
    chk("R2 code 7 no stall", {31'd0, mem_stall}, 0);
    tick(1);

    // back-to-back (R10)
    @(negedge clk);
    ex_valid = 1'b1; ex_kind = 3'd0; ex_tag = 8'hA0; exp_q.push_back('{3'd0, 8'hA0});
    @(negedge clk);
    ex_tag = 8'hA1; exp_q.push_back('{3'd0, 8'hA1});
    @(negedge clk);
    chk("R10 first retires", {23'd0, wb_valid, wb_tag}, {23'd0, 1'b1, 8'hA0});
    ex_tag = 8'hA2; exp_q.push_back('{3'd0, 8'hA2});
    @(negedge clk);
    ex_valid = 1'b0;
    chk("R10 second retires", {23'd0, wb_valid, wb_tag}, {23'd0, 1'b1, 8'hA1});
    chk("R10 no stall", {31'd0, mem_stall}, 0);
    @(negedge clk);
    chk("R10 third retires", {23'd0, wb_valid, wb_tag}, {23'd0, 1'b1, 8'hA2});

    // write barrier (R3, R4, R8)
    wbuf_empty = 1'b0;
    issue(3'd2, 8'h21);
    chk("R3 write raises drain only", {29'd0, mem_stall, need_bar, need_drain}, 3'b101);
    tick(5);
    chk("R8 still stalled", {30'd0, mem_stall, wb_valid}, 2'b10);
    wbuf_empty = 1'b1;
    tick(1);
    chk("R4 stall released", {30'd0, mem_stall, wb_valid}, 2'b00);
    tick(1);
    chk("R4 write barrier retires", {23'd0, wb_valid, wb_tag}, {23'd0, 1'b1, 8'h21});

    // acks while idle are ignored (R11), then full barrier (R3, R5, R11)
    cpu_ack = 4'hF;
    tick(1);
    cpu_ack = 4'h0;
    issue(3'd1, 8'h31);
    chk("R3 full raises bar only", {29'd0, mem_stall, need_bar, need_drain}, 3'b110);
    chk("R5 broadcast pulse", {31'd0, bar_req_out}, 1);
    cpu_ack = 4'b0001;
    tick(1);
    chk("R5 pulse one cycle", {31'd0, bar_req_out}, 0);
    cpu_ack = 4'b0100;
    tick(1);
    cpu_ack = 4'b0000;
    tick(3);
    chk("R11 absent/idle acks ignored", {31'd0, mem_stall}, 1);
    wbuf_empty = 1'b0;
    cpu_ack = 4'b1010;
    tick(1);
    cpu_ack = 4'b0000;
    tick(3);
    chk("R5 waits for write buffer", {31'd0, mem_stall}, 1);
    wbuf_empty = 1'b1;
    tick(1);
    chk("R5 released", {31'd0, mem_stall}, 0);
    tick(1);
    chk("R5 full barrier retires", {23'd0, wb_valid, wb_tag}, {23'd0, 1'b1, 8'h31});

    // exception barrier (R3, R6)
    older_cnt = 4'd2;
    issue(3'd3, 8'h41);
    chk("R3 exception raises bar", {29'd0, mem_stall, need_bar, need_drain}, 3'b110);
    tick(3);
    chk("R6 waits older", {31'd0, mem_stall}, 1);
    older_cnt = 4'd0; exc_pending = 1'b1;
    tick(3);
    chk("R6 waits exception", {31'd0, mem_stall}, 1);
    exc_pending = 1'b0;
    tick(1);
    chk("R6 released", {31'd0, mem_stall}, 0);
    tick(1);
    chk("R6 retires", {23'd0, wb_valid, wb_tag}, {23'd0, 1'b1, 8'h41});

    // trap barrier (R3, R7)
    fp_trap_cnt = 4'd1; exc_pending = 1'b1; older_cnt = 4'd3;
    issue(3'd4, 8'h51);
    chk("R3 trap raises bar", {29'd0, mem_stall, need_bar, need_drain}, 3'b110);
    tick(3);
    chk("R7 waits trap count", {31'd0, mem_stall}, 1);
    fp_trap_cnt = 4'd0;
    tick(1);
    chk("R7 released despite exception", {31'd0, mem_stall}, 0);
    tick(1);
    chk("R7 retires", {23'd0, wb_valid, wb_tag}, {23'd0, 1'b1, 8'h51});
    exc_pending = 1'b0; older_cnt = 4'd0;

    // flush (R9)
    issue(3'd1, 8'h61);
    cpu_ack = 4'b0011;
    tick(1);
    cpu_ack = 4'b0000;
    flush = 1'b1;
    void'(exp_q.pop_back());
    tick(1);
    flush = 1'b0;
    chk("R9 flush empties slot", {28'd0, mem_stall, need_bar, need_drain, wb_valid}, 0);
    tick(2);
    chk("R9 no retirement", {31'd0, wb_valid}, 0);
    issue(3'd1, 8'h62);
    cpu_ack = 4'b1000;
    tick(1);
    cpu_ack = 4'b0000;
    tick(3);
    chk("R9 old acks cleared", {31'd0, mem_stall}, 1);
    cpu_ack = 4'b0011;
    tick(1);
    cpu_ack = 4'b0000;
    tick(1);
    chk("R9 released after fresh acks", {31'd0, mem_stall}, 0);
    tick(1);
    chk("R9 retires", {23'd0, wb_valid, wb_tag}, {23'd0, 1'b1, 8'h62});

    tick(3);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule